// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable single-port memory with registered address and control and a two-stage read pipeline. The array is a register file of `DEPTH` words, each made of `LANES` byte lanes of `LANE_W` bits. An access is begun by one of two active-low start strobes. The processor-side strobe always opens a read. The controller-side strobe opens either a read or a write, and it samples the write inputs on its own edge. After a start, a burst counter walks through `BURST_LEN` consecutive locations, but only on edges where the advance input is low.

The data bus is split into an input word and an output word with a drive flag, so no bidirectional pins are needed. The drive flag is gated asynchronously by an active-low output enable. A sleep input parks the block in a power-down state that keeps the array contents. It enforces a recovery window before new strobes may be issued.

Top module: `pbsram_top`

## Requirements
- R1: A read accessed on rising edge k drives its word on `rdata_o` with `rdata_oe_o` high after edge k+1, and not after edge k alone.
- R2: On an edge where `pstb_n` is low and `sel_pri_n` is low, a read begins at `addr_i` if all three selects are active (`sel_pri_n`=0, `sel_hi`=1, `sel_lo_n`=0). The write inputs and `adv_n` are ignored on that edge, and the burst offset restarts at 0.
- R3: `cstb_n` low begins a cycle only when the processor strobe is not taking effect. The write inputs are sampled on that same edge, so a single-beat write is possible.
- R4: While `sel_pri_n` is high, `pstb_n` has no effect. A strobe that is taken with any select inactive ends the burst, and the drive flag falls once the pipeline has drained.
- R5: With no strobe taken during an open burst, `adv_n`=0 moves to the next burst offset and `adv_n`=1 repeats the current address. Each such edge is a read or a write according to the write inputs.
- R6: Burst address bits [log2(BURST_LEN)-1:0] are `start ^ offset` when `ilv_mode`=1 and `(start + offset) mod BURST_LEN` when it is 0. The upper bits stay fixed. After `BURST_LEN` advances the offset wraps back to the start.
- R7: `gwe_n`=0 writes every lane. Otherwise `bwe_n`=0 writes each lane i (bits 8i+7:8i for the default lane width) whose `lane_we_n[i]` is 0. `bwe_n`=1, or no lane enabled, means a read.
- R8: After any edge that performs a write, `rdata_oe_o` is low, whatever `oe_n` is.
- R9: `oe_n`=1 forces `rdata_oe_o` low at once, without waiting for a clock.
- R10: `sleep_i` sampled high on `ENTER_CYC` (2) edges puts the block to sleep. While asleep, outputs are off and the array is kept. The edge that samples `sleep_i` low leaves sleep, and the next `WAKE_CYC` (2) edges are a recovery window. No strobe may be sampled low from the first sampled-high edge to the end of that window.
- R11: Reset leaves the block deselected, with no burst open and `rdata_oe_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address taken on a start edge |
| pstb_n | input | 1 | Processor-side start strobe, active low |
| cstb_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_pri_n | input | 1 | Primary select, active low; also gates `pstb_n` |
| sel_hi | input | 1 | Secondary select, active high |
| sel_lo_n | input | 1 | Tertiary select, active low |
| gwe_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Power-down request, active high |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data |
| rdata_oe_o | output | 1 | High when `rdata_o` is driven |

## Verification
A write beat can land on the same edge where read data from the previous beat is still in the pipeline. The write must then suppress the output flag while that read word moves to the output register. The bench provokes this by opening a read burst and turning its second edge into a global write with `oe_n` held low. It judges the result by the drive flag dropping right after that edge and coming back two edges later with the following burst address. A single read then confirms that the written word reached the expected location.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
   // access performed by the array on the current rising edge
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_RD   = 2'd1,
      ACC_WR   = 2'd2
   } acc_e;
endpackage

// File: rtl/pbsram_pwr.sv
module pbsram_pwr #(
   parameter int ENTER_CYC = 2,
   parameter int WAKE_CYC  = 2,
   localparam int EW = (ENTER_CYC > 1) ? $clog2(ENTER_CYC) : 1,
   localparam int RW = $clog2(WAKE_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_i,
   output logic asleep_o,
   output logic blocked_o
);
   localparam logic [EW-1:0] ENT_LAST = EW'(ENTER_CYC - 1);
   localparam logic [RW-1:0] REC_INIT = RW'(WAKE_CYC);

   logic [EW-1:0] ent_q;
   logic [RW-1:0] rec_q;
   logic          asleep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_q    <= '0;
         rec_q    <= '0;
         asleep_q <= 1'b0;
      end else if (sleep_i) begin
         rec_q <= '0;
         if (!asleep_q) begin
            if (ent_q == ENT_LAST) begin
               asleep_q <= 1'b1;
               ent_q    <= '0;
            end else begin
               ent_q <= ent_q + 1'b1;
            end
         end
      end else begin
         ent_q <= '0;
         if (asleep_q) begin
            asleep_q <= 1'b0;
            rec_q    <= REC_INIT;
         end else if (rec_q != '0) begin
            rec_q <= rec_q - 1'b1;
         end
      end
   end

   assign asleep_o  = asleep_q;
   assign blocked_o = sleep_i | asleep_q | (rec_q != '0);
endmodule

// File: rtl/pbsram_seq.sv
module pbsram_seq
   import pbsram_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int LANES     = 4,
   parameter int BURST_LEN = 4,
   localparam int BB = $clog2(BURST_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blocked_i,
   input  logic              pstb_n,
   input  logic              cstb_n,
   input  logic              adv_n,
   input  logic              sel_pri_n,
   input  logic              sel_hi,
   input  logic              sel_lo_n,
   input  logic              gwe_n,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic              ilv_mode,
   input  logic [ADDR_W-1:0] addr_i,
   output acc_e              acc_o,
   output logic [ADDR_W-1:0] acc_addr_o,
   output logic [LANES-1:0]  acc_lanes_o,
   output logic              start_o,
   output logic              cont_o,
   output logic              active_o,
   output logic [BB-1:0]     off_o
);
   logic              act_q, act_d;
   logic [BB-1:0]     cnt_q, cnt_d;
   logic [ADDR_W-1:0] base_q, base_d;
   logic              sel_all, p_take, c_take;
   logic [LANES-1:0]  wr_lanes;
   logic [BB-1:0]     lo, idx;

   assign sel_all = !sel_pri_n && sel_hi && !sel_lo_n;
   // the processor strobe is gated by the primary select alone
   assign p_take  = !pstb_n && !sel_pri_n;
   assign c_take  = !cstb_n && !p_take;

   always_comb begin
      if (!gwe_n)      wr_lanes = {LANES{1'b1}};
      else if (!bwe_n) wr_lanes = ~lane_we_n;
      else             wr_lanes = '0;
   end

   always_comb begin
      act_d       = act_q;
      cnt_d       = cnt_q;
      base_d      = base_q;
      acc_o       = ACC_NONE;
      acc_lanes_o = '0;
      start_o     = 1'b0;
      cont_o      = 1'b0;
      if (blocked_i) begin
         act_d = 1'b0;
         cnt_d = '0;
      end else if (p_take) begin
         act_d = sel_all;
         if (sel_all) begin
            base_d  = addr_i;
            cnt_d   = '0;
            acc_o   = ACC_RD;
            start_o = 1'b1;
         end
      end else if (c_take) begin
         act_d = sel_all;
         if (sel_all) begin
            base_d      = addr_i;
            cnt_d       = '0;
            start_o     = 1'b1;
            acc_lanes_o = wr_lanes;
            acc_o       = (|wr_lanes) ? ACC_WR : ACC_RD;
         end
      end else if (act_q) begin
         cont_o      = 1'b1;
         if (!adv_n) cnt_d = cnt_q + 1'b1;
         acc_lanes_o = wr_lanes;
         acc_o       = (|wr_lanes) ? ACC_WR : ACC_RD;
      end
   end

   assign lo  = base_d[BB-1:0];
   assign idx = ilv_mode ? (lo ^ cnt_d) : (lo + cnt_d);
   assign acc_addr_o = {base_d[ADDR_W-1:BB], idx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         cnt_q  <= '0;
         base_q <= '0;
      end else begin
         act_q  <= act_d;
         cnt_q  <= cnt_d;
         base_q <= base_d;
      end
   end

   assign active_o = act_q;
   assign off_o    = cnt_q;
endmodule

// File: rtl/pbsram_store.sv
module pbsram_store
   import pbsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   localparam int DW    = LANE_W * LANES,
   localparam int WORDS = 2 ** ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_e              acc_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LANES-1:0]  lanes_i,
   input  logic [DW-1:0]     wdata_i,
   output logic [DW-1:0]     q_o,
   output logic              q_vld_o
);
   logic [DW-1:0] mem [WORDS];
   logic [DW-1:0] wmask;
   logic [DW-1:0] s1_q;
   logic          s1_v;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign wmask[g*LANE_W +: LANE_W] = {LANE_W{lanes_i[g]}};
   end

   always_ff @(posedge clk) begin
      if (acc_i == ACC_WR)
         mem[addr_i] <= (mem[addr_i] & ~wmask) | (wdata_i & wmask);
   end

   // stage 1 captures the array word, stage 2 drives it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q    <= '0;
         s1_v    <= 1'b0;
         q_o     <= '0;
         q_vld_o <= 1'b0;
      end else begin
         s1_v <= (acc_i == ACC_RD);
         if (acc_i == ACC_RD) s1_q <= mem[addr_i];
         q_o     <= s1_q;
         q_vld_o <= s1_v && (acc_i != ACC_WR);
      end
   end
endmodule

// File: rtl/pbsram_top.sv
module pbsram_top
   import pbsram_pkg::*;
#(
   parameter int DEPTH     = 64,
   parameter int LANE_W    = 8,
   parameter int LANES     = 4,
   parameter int BURST_LEN = 4,
   parameter int ENTER_CYC = 2,
   parameter int WAKE_CYC  = 2,
   localparam int ADDR_W   = $clog2(DEPTH),
   localparam int DW       = LANE_W * LANES,
   localparam int BB       = $clog2(BURST_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              pstb_n,
   input  logic              cstb_n,
   input  logic              adv_n,
   input  logic              sel_pri_n,
   input  logic              sel_hi,
   input  logic              sel_lo_n,
   input  logic              gwe_n,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic              oe_n,
   input  logic              sleep_i,
   input  logic              ilv_mode,
   input  logic [DW-1:0]     wdata_i,
   output logic [DW-1:0]     rdata_o,
   output logic              rdata_oe_o
);
   if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_burst
      $error("BURST_LEN must be a power of two of at least 2");
   end
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2 * BURST_LEN) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2*BURST_LEN");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("LANES and LANE_W must be positive");
   end
   if (ENTER_CYC < 1 || WAKE_CYC < 1) begin : g_bad_pwr
      $error("ENTER_CYC and WAKE_CYC must be positive");
   end

   acc_e              acc_w;
   logic [ADDR_W-1:0] acc_addr_w;
   logic [LANES-1:0]  acc_lanes_w;
   logic              blocked_w, asleep_w;
   logic              start_w, cont_w, act_w;
   logic [BB-1:0]     off_w;
   logic [DW-1:0]     q_w;
   logic              q_vld_w;
   logic              acc_rd_w, acc_wr_w;

   pbsram_pwr #(.ENTER_CYC(ENTER_CYC), .WAKE_CYC(WAKE_CYC)) u_pwr (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_i   (sleep_i),
      .asleep_o  (asleep_w),
      .blocked_o (blocked_w)
   );

   pbsram_seq #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_LEN(BURST_LEN)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .blocked_i   (blocked_w),
      .pstb_n      (pstb_n),
      .cstb_n      (cstb_n),
      .adv_n       (adv_n),
      .sel_pri_n   (sel_pri_n),
      .sel_hi      (sel_hi),
      .sel_lo_n    (sel_lo_n),
      .gwe_n       (gwe_n),
      .bwe_n       (bwe_n),
      .lane_we_n   (lane_we_n),
      .ilv_mode    (ilv_mode),
      .addr_i      (addr_i),
      .acc_o       (acc_w),
      .acc_addr_o  (acc_addr_w),
      .acc_lanes_o (acc_lanes_w),
      .start_o     (start_w),
      .cont_o      (cont_w),
      .active_o    (act_w),
      .off_o       (off_w)
   );

   pbsram_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_i   (acc_w),
      .addr_i  (acc_addr_w),
      .lanes_i (acc_lanes_w),
      .wdata_i (wdata_i),
      .q_o     (q_w),
      .q_vld_o (q_vld_w)
   );

   assign acc_rd_w   = (acc_w == ACC_RD);
   assign acc_wr_w   = (acc_w == ACC_WR);
   assign rdata_o    = q_w;
   assign rdata_oe_o = q_vld_w && !oe_n && !asleep_w;
endmodule

// File: rtl/pbsram_chk.sv
module pbsram_chk #(
   parameter int BURST_LEN = 4,
   localparam int OW = $clog2(BURST_LEN)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          oe_n,
   input logic          pstb_n,
   input logic          cstb_n,
   input logic          sel_pri_n,
   input logic          adv_n,
   input logic          rdata_oe,
   input logic          blocked,
   input logic          asleep,
   input logic          acc_rd,
   input logic          acc_wr,
   input logic          start,
   input logic          cont,
   input logic          burst_on,
   input logic [OW-1:0] off
);
   // R1: driven data comes from a read two edges back
   assert_rd_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> $past(acc_rd, 2));

   // R2: a start opens the burst at offset zero
   assert_start_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (burst_on && off == '0));

   // R5: advance steps the offset, otherwise it holds
   assert_adv_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cont && !adv_n) |=> off == OW'($past(off) + 1'b1));
   assert_adv_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cont && adv_n) |=> $stable(off));

   // R8: a write turns the drive flag off after its edge
   assert_wr_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr |=> !rdata_oe);

   // R9: output enable high means no drive
   assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !rdata_oe);

   // R10: no drive while asleep, and no strobe in sleep or recovery
   assert_sleep_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> !rdata_oe);
   assert_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |-> (cstb_n && (pstb_n || sel_pri_n)));

   // R11: leaving reset finds the block idle
   assert_reset_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!rdata_oe && !burst_on));
endmodule

bind pbsram_top pbsram_chk #(.BURST_LEN(BURST_LEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .oe_n      (oe_n),
   .pstb_n    (pstb_n),
   .cstb_n    (cstb_n),
   .sel_pri_n (sel_pri_n),
   .adv_n     (adv_n),
   .rdata_oe  (rdata_oe_o),
   .blocked   (blocked_w),
   .asleep    (asleep_w),
   .acc_rd    (acc_rd_w),
   .acc_wr    (acc_wr_w),
   .start     (start_w),
   .cont      (cont_w),
   .burst_on  (act_w),
   .off       (off_w)
);

// File: tb/tb_pbsram_top.sv
module tb_pbsram_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [5:0]  addr_i;
   logic        pstb_n, cstb_n, adv_n;
   logic        sel_pri_n, sel_hi, sel_lo_n;
   logic        gwe_n, bwe_n;
   logic [3:0]  lane_we_n;
   logic        oe_n, sleep_i, ilv_mode;
   logic [31:0] wdata_i;
   logic [31:0] rdata_o;
   logic        rdata_oe_o;

   int          n_chk = 0;
   int          n_err = 0;
   logic [31:0] ref_mem [64];

   always #10 clk = ~clk;

   pbsram_top dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .pstb_n(pstb_n),
      .cstb_n(cstb_n), .adv_n(adv_n), .sel_pri_n(sel_pri_n),
      .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .gwe_n(gwe_n), .bwe_n(bwe_n),
      .lane_we_n(lane_we_n), .oe_n(oe_n), .sleep_i(sleep_i),
      .ilv_mode(ilv_mode), .wdata_i(wdata_i), .rdata_o(rdata_o),
      .rdata_oe_o(rdata_oe_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle();
      pstb_n = 1'b1; cstb_n = 1'b1; adv_n = 1'b1;
      sel_pri_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
      gwe_n = 1'b1; bwe_n = 1'b1; lane_we_n = 4'hF; oe_n = 1'b0;
      addr_i = '0; wdata_i = '0;
   endtask

   function automatic logic [5:0] beat_addr(input logic [5:0] base, input int k, input logic ilv);
      logic [1:0] o;
      o = k[1:0];
      return {base[5:2], ilv ? (base[1:0] ^ o) : (base[1:0] + o)};
   endfunction

   function automatic logic [31:0] lane_mask(input logic g, input logic b, input logic [3:0] ln);
      logic [31:0] m = '0;
      for (int i = 0; i < 4; i++)
         if (!g || (!b && !ln[i])) m[i*8 +: 8] = 8'hFF;
      return m;
   endfunction

   // ends any open burst with a deselecting controller strobe (R4)
   task automatic drop();
      idle(); cstb_n = 1'b0; sel_lo_n = 1'b1;
      tick();
      idle();
      tick();
   endtask

   task automatic wr_ctrl(input logic [5:0] a, input logic [31:0] d,
                          input logic g, input logic b, input logic [3:0] ln);
      logic [31:0] m;
      idle(); cstb_n = 1'b0; addr_i = a; wdata_i = d;
      gwe_n = g; bwe_n = b; lane_we_n = ln;
      tick();
      m = lane_mask(g, b, ln);
      ref_mem[a] = (ref_mem[a] & ~m) | (d & m);
      drop();
   endtask

   task automatic rd_single(input logic [5:0] a, input string tag);
      idle(); pstb_n = 1'b0; addr_i = a;
      gwe_n = 1'b0; wdata_i = 32'hDEAD_BEEF;   // ignored on a processor start (R2)
      tick();
      chk({tag, " R1 not yet driven"}, {31'd0, rdata_oe_o}, 32'd0);
      idle();
      tick();
      chk({tag, " R1 driven"}, {31'd0, rdata_oe_o}, 32'd1);
      chk({tag, " data"}, rdata_o, ref_mem[a]);
      drop();
      chk({tag, " R4 released"}, {31'd0, rdata_oe_o}, 32'd0);
   endtask

   task automatic wr_burst(input logic [5:0] base, input logic ilv, input logic [31:0] seed);
      idle(); ilv_mode = ilv;
      for (int j = 0; j < 4; j++) begin
         idle(); gwe_n = 1'b0; wdata_i = seed + 32'(j);
         if (j == 0) begin cstb_n = 1'b0; addr_i = base; end
         else adv_n = 1'b0;
         tick();
         ref_mem[beat_addr(base, j, ilv)] = seed + 32'(j);
      end
      drop();
   endtask

   // advp[j] = 1 means adv_n low on edge j (j >= 1)
   task automatic rd_seq(input logic [5:0] base, input logic ilv, input int n,
                         input logic [15:0] advp, input string tag);
      logic [5:0] ea [16];
      int k = 0;
      ilv_mode = ilv;
      for (int j = 0; j < n; j++) begin
         idle();
         if (j == 0) begin pstb_n = 1'b0; addr_i = base; adv_n = 1'b0; end
         else if (advp[j]) begin adv_n = 1'b0; k++; end
         ea[j] = beat_addr(base, k, ilv);
         tick();
         if (j >= 1) chk($sformatf("%s beat %0d", tag, j - 1), rdata_o, ref_mem[ea[j-1]]);
      end
      idle();
      tick();
      chk($sformatf("%s beat %0d", tag, n - 1), rdata_o, ref_mem[ea[n-1]]);
      drop();
   endtask

   task automatic t_reset();
      chk("R11 reset drive flag", {31'd0, rdata_oe_o}, 32'd0);
   endtask

   task automatic t_single();
      wr_ctrl(6'd5, 32'hA5A5_0001, 1'b0, 1'b1, 4'hF);     // R3 single-beat write
      rd_single(6'd5, "R3 R2 single write");
   endtask

   task automatic t_bursts();
      wr_burst(6'd9, 1'b0, 32'h1000_0000);                // R6 linear write 9,10,11,8
      rd_seq(6'd9, 1'b1, 6, 16'h003E, "R6 interleaved wrap R5");
      rd_seq(6'd10, 1'b0, 5, 16'h001E, "R6 linear wrap");
      rd_seq(6'd8, 1'b0, 5, 16'h0012, "R5 wait state hold");
   endtask

   task automatic t_bytes();
      wr_ctrl(6'd20, 32'h1122_3344, 1'b0, 1'b1, 4'hF);
      wr_ctrl(6'd20, 32'hAABB_CCDD, 1'b1, 1'b0, 4'b1010); // R7 lanes 0 and 2
      chk("R7 lane merge model", ref_mem[20], 32'h11BB_33DD);
      rd_single(6'd20, "R7 byte write");
      wr_ctrl(6'd20, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'h0);    // R7 bwe high: read
      wr_ctrl(6'd20, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'hF);    // R7 no lane: read
      rd_single(6'd20, "R7 no write");
      wr_ctrl(6'd20, 32'h5566_7788, 1'b0, 1'b0, 4'b1110); // R7 global overrides
      rd_single(6'd20, "R7 global write");
   endtask

   task automatic t_wr_hiz();
      ilv_mode = 1'b0;
      idle(); pstb_n = 1'b0; addr_i = 6'd9;
      tick();
      idle(); adv_n = 1'b0; gwe_n = 1'b0; wdata_i = 32'hCAFE_0010;
      tick();
      ref_mem[10] = 32'hCAFE_0010;
      chk("R8 write forces off", {31'd0, rdata_oe_o}, 32'd0);
      idle(); adv_n = 1'b0;
      tick();
      idle();
      tick();
      chk("R8 read resumes flag", {31'd0, rdata_oe_o}, 32'd1);
      chk("R8 read resumes data", rdata_o, ref_mem[11]);
      drop();
      rd_single(6'd10, "R8 written beat");
   endtask

   task automatic t_oe_and_select();
      idle(); pstb_n = 1'b0; addr_i = 6'd5;
      tick();
      idle();
      tick();
      oe_n = 1'b1; #2;
      chk("R9 oe high off", {31'd0, rdata_oe_o}, 32'd0);
      oe_n = 1'b0; #2;
      chk("R9 oe low on", {31'd0, rdata_oe_o}, 32'd1);
      idle(); pstb_n = 1'b0; sel_pri_n = 1'b1; addr_i = 6'd20;
      tick();
      tick();
      chk("R4 blocked strobe keeps data", rdata_o, ref_mem[5]);
      chk("R4 blocked strobe keeps flag", {31'd0, rdata_oe_o}, 32'd1);
      idle(); cstb_n = 1'b0; sel_hi = 1'b0;
      tick();
      idle();
      tick();
      chk("R4 deselect off", {31'd0, rdata_oe_o}, 32'd0);
   endtask

   task automatic t_sleep();
      wr_ctrl(6'd30, 32'h0BAD_F00D, 1'b0, 1'b1, 4'hF);
      idle(); pstb_n = 1'b0; addr_i = 6'd30;
      tick();
      idle();
      tick();
      chk("R10 driven before sleep", {31'd0, rdata_oe_o}, 32'd1);
      sleep_i = 1'b1;
      tick();
      tick();
      chk("R10 asleep off", {31'd0, rdata_oe_o}, 32'd0);
      repeat (3) tick();
      chk("R10 still off", {31'd0, rdata_oe_o}, 32'd0);
      sleep_i = 1'b0;
      repeat (3) tick();
      chk("R10 recovered idle", {31'd0, rdata_oe_o}, 32'd0);
      rd_single(6'd30, "R10 contents kept");
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0; sleep_i = 1'b0; ilv_mode = 1'b0;
      idle();
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_single();
      t_bursts();
      t_bytes();
      t_wr_hiz();
      t_oe_and_select();
      t_sleep();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule